// File: doc/BRIEF.md
# Pipelined Signed Booth Multiplier

This block multiplies two 8-bit two's-complement operands and returns their 16-bit two's-complement product. It uses no behavioural multiply. The multiplier operand is recoded into radix-4 Booth digits, and each digit selects zero, the multiplicand, or twice the multiplicand, with or without negation. The resulting partial-product rows are placed at their column weights. A correction row and a row of negation bits join them.

The rows are reduced in two stages. A layer of 3:2 counters comes first, then a pipeline register, then a 4:2 compressor layer that leaves one sum vector and one carry vector. A parallel-prefix carry-lookahead adder merges the two vectors, and the result is registered at the output.

The interface is a plain valid-qualified stream. One operand pair may be presented on every clock. Each pair produces a product exactly two cycles later, together with a valid flag.

Top module: `booth_mul_pipe`

## Requirements
- R1: When `valid_out` is high, `product` equals the signed product of the `a_in` and `b_in` values presented with `valid_in` two rising edges earlier, as a 16-bit two's-complement value.
- R2: `valid_out` is high exactly two cycles after a cycle with `valid_in` high and low two cycles after a cycle with `valid_in` low. Pairs may arrive on back-to-back cycles, and idle gaps in between are allowed.
- R3: Reset (`rst`) is synchronous and active high. It clears both valid stages, so `valid_out` is low in the cycle after any reset edge. Operands presented while reset is high never produce a valid output.
- R4: The multiplier is extended with an implicit 0 below bit 0 and split into four overlapping 3-bit groups (bits 2k+1, 2k, 2k−1). The digit codes are 000/111→0, 001/010→+1, 011→+2, 100→−2 and 101/110→−1. Negation inverts the selected row and adds 1 in column 2k. All rows together equal the product modulo 2^16.
- R5: Sign extension uses an inverted row sign bit plus one precomputed constant row, so extreme operands give exact results: −128 × −128 = +16384, −128 × 127 = −16256, and 127 × −128 = −16256.
- R6: The 3:2 counter layer keeps the total of its inputs modulo 2^16 unchanged.
- R7: The 4:2 compressor layer after the pipeline register keeps the total of its four inputs modulo 2^16 unchanged.
- R8: The carry-lookahead adder output equals the sum of the final sum and carry vectors modulo 2^16.
- R9: Results are exact at the operand extremes and at ±1: every pairing of −128, −127, −1, 0, 1, 126 and 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid stages |
| valid_in | input | 1 | Qualifies `a_in` and `b_in` in this cycle |
| a_in | input | 8 | Multiplicand, two's complement |
| b_in | input | 8 | Multiplier (Booth-recoded), two's complement |
| valid_out | output | 1 | Qualifies `product` |
| product | output | 16 | Signed product, two's complement |

## Verification
The hardest case to reach from the ports is an operand pair that is in flight when reset is raised. That pair is inside the reduction tree, between the 3:2 layer and the output register, so it can only be caught by firing reset while the stream is running. The stimulus does exactly this: it streams valid pairs, raises reset for a single cycle with `valid_in` still high, and then expects no valid output for the two pairs that were in the pipeline. An exhaustive sweep of all 65536 operand pairs, with periodic idle gaps, reaches every Booth digit combination and every carry pattern through the compressor tree and the lookahead adder.

// File: rtl/bmul_pkg.sv
package bmul_pkg;

  // Correction constant for the inverted-sign extension of every Booth row.
  // Row k contributes +2^(aw+1+2k) through its inverted sign bit; this
  // constant removes all of them modulo 2^(2*aw).
  function automatic int unsigned corr_const(input int aw);
    int unsigned acc;
    acc = 0;
    for (int k = 0; k < aw / 2; k++) begin
      acc += 32'd1 << (aw + 1 + 2 * k);
    end
    return ~acc + 32'd1;
  endfunction

endpackage

// File: rtl/booth_pp_gen.sv
module booth_pp_gen #(
  parameter int AW = 8
) (
  input  logic [AW-1:0]                  mcand,
  input  logic [AW-1:0]                  mplier,
  output logic [AW/2+1:0][2*AW-1:0]      rows
);
  localparam int NPP = AW / 2;
  localparam int PPW = AW + 2;
  localparam int PW  = 2 * AW;
  localparam logic [PW-1:0] CORR = PW'(bmul_pkg::corr_const(AW));

  logic [AW:0]     mpx;
  logic [NPP-1:0]  negs;
  logic [PW-1:0]   neg_row;

  assign mpx = {mplier, 1'b0};

  for (genvar k = 0; k < NPP; k++) begin : g_digit
    logic b_lo, b_mid, b_hi;
    logic sel1, sel2, neg;
    logic [PPW-1:0] mag, pp;

    assign b_lo  = mpx[2*k];
    assign b_mid = mpx[2*k+1];
    assign b_hi  = mpx[2*k+2];

    // radix-4 digit decode
    assign sel1 = b_lo ^ b_mid;
    assign sel2 = (b_hi & ~b_mid & ~b_lo) | (~b_hi & b_mid & b_lo);
    assign neg  = b_hi & ~(b_mid & b_lo);

    assign mag = sel1 ? {{2{mcand[AW-1]}}, mcand} :
                 (sel2 ? {mcand[AW-1], mcand, 1'b0} : '0);
    assign pp  = mag ^ {PPW{neg}};

    assign negs[k] = neg;
    // sign bit inverted; the constant row settles the rest of the extension
    assign rows[k] = PW'({~pp[PPW-1], pp[PPW-2:0]}) << (2 * k);
  end

  always_comb begin
    neg_row = '0;
    for (int k = 0; k < NPP; k++) neg_row[2*k] = negs[k];
  end

  assign rows[NPP]   = neg_row;
  assign rows[NPP+1] = CORR;

endmodule

// File: rtl/csa32.sv
module csa32 #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  logic [W-2:0] maj;

  assign s   = x ^ y ^ z;
  assign maj = (x[W-2:0] & y[W-2:0]) | (x[W-2:0] & z[W-2:0]) | (y[W-2:0] & z[W-2:0]);
  assign c   = {maj, 1'b0};

endmodule

// File: rtl/comp42.sv
module comp42 #(
  parameter int W = 16
) (
  input  logic [W-1:0] w,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);
  logic [W-1:0] t;
  logic [W-1:0] cin;
  logic [W-2:0] cout;
  logic [W-2:0] craw;

  assign t      = w ^ x ^ y;
  assign cin[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i > 0) begin : g_cin
      assign cin[i] = cout[i-1];
    end
    assign sum[i] = t[i] ^ z[i] ^ cin[i];
    if (i < W - 1) begin : g_up
      // lateral carry depends only on the first three inputs: no ripple
      assign cout[i] = (w[i] & x[i]) | (w[i] & y[i]) | (x[i] & y[i]);
      assign craw[i] = (t[i] & z[i]) | (t[i] & cin[i]) | (z[i] & cin[i]);
    end
  end

  assign carry = {craw, 1'b0};

endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  localparam int LV = $clog2(W);

  logic [W-1:0]            p0;
  logic [LV:0][W-2:0]      g;
  logic [LV-1:0][W-2:0]    p;

  assign p0 = a ^ b;

  // parallel-prefix generate/propagate network
  always_comb begin
    g    = '0;
    p    = '0;
    g[0] = a[W-2:0] & b[W-2:0];
    p[0] = p0[W-2:0];
    for (int l = 0; l < LV; l++) begin
      for (int i = 0; i < W - 1; i++) begin
        logic gprev, pprev;
        gprev = (i >= (1 << l)) ? g[l][i-(1<<l)] : 1'b0;
        pprev = (i >= (1 << l)) ? p[l][i-(1<<l)] : 1'b1;
        g[l+1][i] = g[l][i] | (p[l][i] & gprev);
        if (l < LV - 1) p[l+1][i] = p[l][i] & pprev;
      end
    end
  end

  assign sum = p0 ^ {g[LV], 1'b0};

endmodule

// File: rtl/booth_mul_pipe.sv
module booth_mul_pipe #(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_in,
  input  logic [AW-1:0]     a_in,
  input  logic [AW-1:0]     b_in,
  output logic              valid_out,
  output logic [2*AW-1:0]   product
);
  // tree shape below is laid out for four Booth rows plus two extra rows
  localparam int PW   = 2 * AW;
  localparam int NROW = AW / 2 + 2;
  localparam int NGRP = NROW / 3;

  logic [NROW-1:0][PW-1:0] rows;
  logic [NGRP-1:0][PW-1:0] cs_s, cs_c;
  logic [NGRP-1:0][PW-1:0] st_s, st_c;
  logic                    st_v;
  logic [PW-1:0]           sum42, carry42, total;

  booth_pp_gen #(.AW(AW)) u_pp (
    .mcand  (a_in),
    .mplier (b_in),
    .rows   (rows)
  );

  // stage 1: 3:2 counters on row triples
  for (genvar g = 0; g < NGRP; g++) begin : g_csa
    csa32 #(.W(PW)) u_csa (
      .x (rows[3*g]),
      .y (rows[3*g+1]),
      .z (rows[3*g+2]),
      .s (cs_s[g]),
      .c (cs_c[g])
    );
  end

  // pipeline register inside the tree
  always_ff @(posedge clk) begin
    st_s <= cs_s;
    st_c <= cs_c;
    if (rst) st_v <= 1'b0;
    else     st_v <= valid_in;
  end

  // stage 2: 4:2 compressor, then lookahead adder
  comp42 #(.W(PW)) u_c42 (
    .w     (st_s[0]),
    .x     (st_c[0]),
    .y     (st_s[1]),
    .z     (st_c[1]),
    .sum   (sum42),
    .carry (carry42)
  );

  cla_adder #(.W(PW)) u_cla (
    .a   (sum42),
    .b   (carry42),
    .sum (total)
  );

  always_ff @(posedge clk) begin
    product <= total;
    if (rst) valid_out <= 1'b0;
    else     valid_out <= st_v;
  end

  // ---------------- assertions ----------------
  logic signed [PW-1:0] ref_now;
  logic [PW-1:0]        row_total;

  assign ref_now = $signed(a_in) * $signed(b_in);

  always_comb begin
    row_total = '0;
    for (int r = 0; r < NROW; r++) row_total = row_total + rows[r];
  end

  AST_PP_ROWS: assert property (@(posedge clk) disable iff (rst)
    valid_in |-> (row_total == ref_now)); // R4
  AST_CSA_KEEP: assert property (@(posedge clk) disable iff (rst)
    valid_in |-> ((cs_s[0] + cs_c[0] + cs_s[1] + cs_c[1]) == row_total)); // R6
  AST_TREE_KEEP: assert property (@(posedge clk) disable iff (rst)
    st_v |-> ((sum42 + carry42) == (st_s[0] + st_c[0] + st_s[1] + st_c[1]))); // R7
  AST_CLA_ADD: assert property (@(posedge clk) disable iff (rst)
    st_v |-> (total == sum42 + carry42)); // R8
  AST_LAT_VALID: assert property (@(posedge clk) disable iff (rst)
    valid_in |-> ##2 valid_out); // R2
  AST_LAT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !valid_in |-> ##2 !valid_out); // R2
  AST_PRODUCT: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> ($signed(product) == $past(ref_now, 2))); // R1
  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> !valid_out); // R3

endmodule

// File: tb/test_booth_mul_pipe.sv
module test_booth_mul_pipe;
  localparam int AW = 8;
  localparam int PW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          valid_in = 1'b0;
  logic [AW-1:0] a_in = '0;
  logic [AW-1:0] b_in = '0;
  logic          valid_out;
  logic [PW-1:0] product;

  booth_mul_pipe #(.AW(AW)) i_booth_mul_pipe (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (valid_in),
    .a_in      (a_in),
    .b_in      (b_in),
    .valid_out (valid_out),
    .product   (product)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  bit chk_en = 1'b0;

  // expectation history: h0 = pair driven last step, h1 = the one before
  logic                 h0v = 1'b0, h1v = 1'b0;
  logic signed [PW-1:0] h0e = '0, h1e = '0;
  string                h0t = "R3", h1t = "R3";

  task automatic check_out();
    total++;
    if (h1v) begin
      if (valid_out !== 1'b1 || $signed(product) !== h1e) begin
        bad++;
        $display("FAIL %s: valid=%0b product=%0d expected valid=1 product=%0d",
                 h1t, valid_out, $signed(product), h1e);
      end
    end else if (valid_out !== 1'b0) begin
      bad++;
      $display("FAIL %s: valid=%0b expected valid=0", h1t, valid_out);
    end
  endtask

  task automatic step(input logic v, input logic r, input logic [AW-1:0] a,
                      input logic [AW-1:0] b, input string tag);
    @(negedge clk);
    if (chk_en) check_out();
    h1v = h0v; h1e = h0e; h1t = h0t;
    if (r) begin
      h1v = 1'b0;
      h1t = tag;
    end
    h0v = v & ~r;
    h0e = $signed(a) * $signed(b);
    h0t = tag;
    rst = r; valid_in = v; a_in = a; b_in = b;
  endtask

  logic [AW-1:0] corner [7] = '{8'h80, 8'h81, 8'hFF, 8'h00, 8'h01, 8'h7E, 8'h7F};
  logic [AW-1:0] bpat   [8] = '{8'h55, 8'hAA, 8'h33, 8'hCC, 8'h66, 8'h99, 8'h0F, 8'hF0};
  logic [AW-1:0] apat   [5] = '{8'h80, 8'hFD, 8'h01, 8'h4D, 8'h7F};

  initial begin
    // R3: reset state, operands offered during reset are dropped
    step(1'b0, 1'b1, 8'h00, 8'h00, "R3");
    step(1'b0, 1'b1, 8'h00, 8'h00, "R3");
    chk_en = 1'b1;
    step(1'b1, 1'b1, 8'h05, 8'h07, "R3");
    step(1'b1, 1'b1, 8'h80, 8'h80, "R3");
    // R5: sign-extension extremes
    step(1'b1, 1'b0, 8'h80, 8'h80, "R5");
    step(1'b1, 1'b0, 8'h80, 8'h7F, "R5");
    step(1'b1, 1'b0, 8'h7F, 8'h80, "R5");
    // R9: extremes and +/-1, back to back
    foreach (corner[i]) foreach (corner[j])
      step(1'b1, 1'b0, corner[i], corner[j], "R9");
    // R4: multiplier patterns covering every digit code
    foreach (apat[i]) foreach (bpat[j])
      step(1'b1, 1'b0, apat[i], bpat[j], "R4");
    step(1'b0, 1'b0, 8'h12, 8'h34, "R2");
    step(1'b0, 1'b0, 8'h56, 8'h78, "R2");
    // R3: reset while two pairs are in flight
    step(1'b1, 1'b0, 8'h11, 8'h22, "R1");
    step(1'b1, 1'b0, 8'h33, 8'h44, "R1");
    step(1'b1, 1'b0, 8'h55, 8'h66, "R1");
    step(1'b1, 1'b1, 8'h77, 8'h88, "R3");
    step(1'b1, 1'b0, 8'h99, 8'hAA, "R1");
    // R1/R6/R7/R8 exhaustive sweep; R2 idle gaps
    for (int n = 0; n < 65536; n++) begin
      step(1'b1, 1'b0, n[15:8], n[7:0], "R1/R6/R7/R8");
      if (n % 5 == 4) step(1'b0, 1'b0, n[7:0], ~n[15:8], "R2");
    end
    step(1'b0, 1'b0, 8'h00, 8'h00, "R2");
    step(1'b0, 1'b0, 8'h00, 8'h00, "R2");
    step(1'b0, 1'b0, 8'h00, 8'h00, "R2");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule